// File: doc/BRIEF.md
# Operand staging controller for a slow combinational core

This block lets a host on a fast clock drive a combinational compute core that needs a long settle time and therefore sits on a much slower clock. The host uses a simple register port to write five 32-bit operand words. It then sets a start bit and polls a status word. When the status reports completion, the host reads five 32-bit result words. Between these steps, only two single-bit toggles cross between the two clock domains: start goes from fast to slow, and done comes back from slow to fast. The operand and result data stay stable while the handshake is in flight, so they are never synchronized bit by bit.

On the slow clock, the five operands are presented to the core as one packed 160-bit word, with word k in bits 32k+31:32k. The core's packed result uses the same layout. It is captured one slow edge after the operands are driven, which gives the core a full slow period to settle. A parameter can replace the returning done toggle with a fixed fast-cycle wait count. The default build uses the toggle handshake.

Top module: `opstage_ctrl`

## Requirements
- R1: After reset, the control/status word (address 5) reads 0 and the five result words (addresses 6 to 10) read 0.
- R2: While the block is idle, a write to address k (0 to 4) stores the operand word, and a read of address k returns it.
- R3: The control/status word at address 5 has these fields. Bit 0 is start: writing 1 requests a run, and the bit always reads back 0. Bit 1 is busy. Bit 2 is done.
- R4: A start write accepted while idle shows busy=1 and done=0 on the next fast cycle.
- R5: During a run, the core input port carries operand word k in bits 32k+31:32k. It holds that value until the next accepted start.
- R6: After completion, result word k (read at address 6+k) equals bits 32k+31:32k of the core output, as computed from the staged operands.
- R7: Each run completes on its own. Busy falls and done rises together, and busy and done are never both set.
- R8: Operand writes made while busy are ignored. The operand registers read back the values from before the run, and the results are computed from those values.
- R9: A start write made while busy is ignored. No second run follows: done stays 1 and busy stays 0 afterwards.
- R10: Writes to result addresses and to unmapped addresses have no effect. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_f | input | 1 | Fast host clock |
| rst_f_n | input | 1 | Active-low reset of the fast domain, released synchronously |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 4 | Register word address |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data for host_addr (combinational) |
| clk_s | input | 1 | Slow core clock |
| rst_s_n | input | 1 | Active-low reset of the slow domain, released synchronously |
| core_opnd | output | 160 | Packed operands to the combinational core |
| core_rslt | input | 160 | Packed result from the combinational core |

## Verification
The hardest cases to reach are the two "ignored while busy" cases. A host write has to land inside the run window, and that window lasts several slow periods plus two synchronizer delays in each direction. The bench issues its start and then writes the offending operand or start on the very next fast cycles, well inside that window. It then lets the run finish and waits many further slow periods. This shows that the stray start did not trigger a hidden second run, and that the results still come from the original operands. A behavioural core model in the bench mixes neighbouring words, so a misplaced word in the packing changes the expected result.

// File: rtl/opstage_pkg.sv
package opstage_pkg;
   // control/status bit positions
   localparam int unsigned CS_START = 0;
   localparam int unsigned CS_BUSY  = 1;
   localparam int unsigned CS_DONE  = 2;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_SETTLE = 1'b1
   } slow_phase_t;
endpackage

// File: rtl/opstage_sync.sv
module opstage_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("opstage_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/opstage_host.sv
module opstage_host
   import opstage_pkg::*;
#(
   parameter int unsigned WORDS      = 5,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 4,
   parameter bit          COUNT_DONE = 1'b0,
   parameter int unsigned WAIT_FAST  = 50
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rdata,
   output logic                     start_tgl,
   input  logic                     done_lvl,
   input  logic [WORDS*DATA_W-1:0]  res_in,
   output logic [WORDS*DATA_W-1:0]  ops_out
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(WORDS);
   localparam int unsigned       CNT_W  = $clog2(WAIT_FAST + 1);

   logic [DATA_W-1:0] ops_q [WORDS];
   logic [DATA_W-1:0] res_q [WORDS];
   logic              busy_q, done_q, done_prev;
   logic              start_acc, finish;

   assign start_acc = we && (addr == CTRL_A) && wdata[CS_START] && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_prev <= 1'b0;
      else        done_prev <= done_lvl;
   end

   generate
      if (COUNT_DONE) begin : g_count
         logic [CNT_W-1:0] wait_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     wait_q <= '0;
            else if (start_acc)             wait_q <= CNT_W'(WAIT_FAST);
            else if (busy_q && wait_q != 0) wait_q <= wait_q - 1'b1;
         end
         assign finish = busy_q && (wait_q == '0);
      end else begin : g_handshake
         assign finish = busy_q && (done_lvl ^ done_prev);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         done_q    <= 1'b0;
         start_tgl <= 1'b0;
      end else if (start_acc) begin
         busy_q    <= 1'b1;
         done_q    <= 1'b0;
         start_tgl <= ~start_tgl;
      end else if (finish) begin
         busy_q <= 1'b0;
         done_q <= 1'b1;
      end
   end

   for (genvar k = 0; k < WORDS; k++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ops_q[k] <= '0;
            res_q[k] <= '0;
         end else begin
            if (we && !busy_q && addr == ADDR_W'(k)) ops_q[k] <= wdata;
            if (finish) res_q[k] <= res_in[k*DATA_W +: DATA_W];
         end
      end
      assign ops_out[k*DATA_W +: DATA_W] = ops_q[k];
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < WORDS; k++) begin
         if (addr == ADDR_W'(k))             rdata = ops_q[k];
         if (addr == ADDR_W'(WORDS + 1 + k)) rdata = res_q[k];
      end
      if (addr == CTRL_A) begin
         rdata[CS_BUSY] = busy_q;
         rdata[CS_DONE] = done_q;
      end
   end

   a_r8_ops_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> $stable(ops_out));
   a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start_acc |=> busy_q && !done_q);
   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_q && done_q));
   a_r9_no_retoggle: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> $stable(start_tgl));
endmodule

// File: rtl/opstage_slow.sv
module opstage_slow
   import opstage_pkg::*;
#(
   parameter int unsigned PACK_W = 160
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_lvl,
   input  logic [PACK_W-1:0] ops_in,
   output logic [PACK_W-1:0] core_opnd,
   input  logic [PACK_W-1:0] core_rslt,
   output logic [PACK_W-1:0] res_q,
   output logic              done_tgl
);
   slow_phase_t phase;
   logic        start_prev, seen;

   assign seen = start_lvl ^ start_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_prev <= 1'b0;
         phase      <= PH_IDLE;
         core_opnd  <= '0;
         res_q      <= '0;
         done_tgl   <= 1'b0;
      end else begin
         start_prev <= start_lvl;
         if (phase == PH_SETTLE) begin
            res_q    <= core_rslt;
            done_tgl <= ~done_tgl;
            phase    <= PH_IDLE;
         end else if (seen) begin
            core_opnd <= ops_in;
            phase     <= PH_SETTLE;
         end
      end
   end

   a_r7_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_SETTLE |=> phase == PH_IDLE && done_tgl != $past(done_tgl));
   a_r5_opnd_held: assert property (@(posedge clk) disable iff (!rst_n)
      !(seen && phase == PH_IDLE) |=> $stable(core_opnd));
endmodule

// File: rtl/opstage_ctrl.sv
module opstage_ctrl #(
   parameter int unsigned WORDS      = 5,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned SYNC_STG   = 2,
   parameter bit          COUNT_DONE = 1'b0,
   parameter int unsigned WAIT_FAST  = 50
) (
   input  logic                    clk_f,
   input  logic                    rst_f_n,
   input  logic                    host_we,
   input  logic [ADDR_W-1:0]       host_addr,
   input  logic [DATA_W-1:0]       host_wdata,
   output logic [DATA_W-1:0]       host_rdata,
   input  logic                    clk_s,
   input  logic                    rst_s_n,
   output logic [WORDS*DATA_W-1:0] core_opnd,
   input  logic [WORDS*DATA_W-1:0] core_rslt
);
   localparam int unsigned PACK_W = WORDS * DATA_W;

   generate
      if (2 * WORDS + 1 > (1 << ADDR_W)) begin : g_bad_map
         $error("address width too small for the register map");
      end
      if (DATA_W < 3) begin : g_bad_width
         $error("data width must hold the control bits");
      end
   endgenerate

   logic              start_tgl, start_lvl, done_tgl, done_lvl;
   logic [PACK_W-1:0] ops_packed, res_slow;

   opstage_host #(
      .WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .COUNT_DONE(COUNT_DONE), .WAIT_FAST(WAIT_FAST)
   ) u_host (
      .clk(clk_f), .rst_n(rst_f_n), .we(host_we), .addr(host_addr),
      .wdata(host_wdata), .rdata(host_rdata), .start_tgl(start_tgl),
      .done_lvl(done_lvl), .res_in(res_slow), .ops_out(ops_packed)
   );

   opstage_sync #(.STAGES(SYNC_STG)) u_sync_start (
      .clk(clk_s), .rst_n(rst_s_n), .d(start_tgl), .q(start_lvl)
   );

   opstage_sync #(.STAGES(SYNC_STG)) u_sync_done (
      .clk(clk_f), .rst_n(rst_f_n), .d(done_tgl), .q(done_lvl)
   );

   opstage_slow #(.PACK_W(PACK_W)) u_slow (
      .clk(clk_s), .rst_n(rst_s_n), .start_lvl(start_lvl), .ops_in(ops_packed),
      .core_opnd(core_opnd), .core_rslt(core_rslt), .res_q(res_slow),
      .done_tgl(done_tgl)
   );
endmodule

// File: tb/opstage_ctrl_test.sv
module opstage_ctrl_test;
   logic         clk_f = 0, clk_s = 0, rst_f_n = 0, rst_s_n = 0;
   logic         host_we = 0;
   logic [3:0]   host_addr = 0;
   logic [31:0]  host_wdata = 0, host_rdata;
   logic [159:0] core_opnd, core_rslt;
   int           checks = 0, errors = 0;
   logic [31:0]  ops [5];

   always #4  clk_f = ~clk_f;   // 125 MHz
   always #40 clk_s = ~clk_s;

   // behavioural combinational core: mixes each word with its neighbour
   always_comb begin
      for (int k = 0; k < 5; k++) begin
         logic [31:0] a, b;
         a = core_opnd[k*32 +: 32];
         b = core_opnd[((k+1)%5)*32 +: 32];
         core_rslt[k*32 +: 32] = a * 32'd3 + ({b[15:0], b[31:16]} ^ 32'(k));
      end
   end

   opstage_ctrl uut (
      .clk_f(clk_f), .rst_f_n(rst_f_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .clk_s(clk_s),
      .rst_s_n(rst_s_n), .core_opnd(core_opnd), .core_rslt(core_rslt)
   );

   function automatic logic [31:0] model(int k);
      logic [31:0] b;
      b = ops[(k+1)%5];
      return ops[k] * 32'd3 + ({b[15:0], b[31:16]} ^ 32'(k));
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk_f);
      host_we = 1; host_addr = a; host_wdata = d;
      @(negedge clk_f);
      host_we = 0;
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] d);
      @(negedge clk_f);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic wait_done(string req);
      logic [31:0] s;
      int n = 0;
      do begin rd(4'd5, s); n++; end while (s[1] && n < 400);
      check(req, s, 32'h4);
   endtask

   task automatic load_ops(logic [31:0] seed);
      for (int k = 0; k < 5; k++) begin
         ops[k] = seed * 32'(k + 7) ^ 32'hA5A5_0000 + 32'(k);
         wr(4'(k), ops[k]);
      end
   endtask

   task automatic check_results(string req);
      logic [31:0] d;
      for (int k = 0; k < 5; k++) begin
         rd(4'(6 + k), d);
         check(req, d, model(k));
      end
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(4'd5, d); check("R1 status", d, 0);
      for (int k = 0; k < 5; k++) begin
         rd(4'(6 + k), d); check("R1 result", d, 0);
      end
   endtask

   task automatic t_basic(logic [31:0] seed);
      logic [31:0] d;
      load_ops(seed);
      for (int k = 0; k < 5; k++) begin
         rd(4'(k), d); check("R2 operand readback", d, ops[k]);
      end
      wr(4'd5, 32'h1);
      rd(4'd5, d); check("R4/R3 busy after start, start reads 0", d, 32'h2);
      wait_done("R7 completion");
      for (int k = 0; k < 5; k++)
         check("R5 packing", core_opnd[k*32 +: 32], ops[k]);
      check_results("R6 results");
   endtask

   task automatic t_busy_writes;
      logic [31:0] d;
      load_ops(32'h1234_5678);
      wr(4'd5, 32'h1);
      wr(4'd0, 32'hDEAD_BEEF);
      wr(4'd3, 32'hCAFE_F00D);
      rd(4'd0, d); check("R8 op0 held", d, ops[0]);
      rd(4'd3, d); check("R8 op3 held", d, ops[3]);
      wait_done("R7 completion busy-writes");
      check_results("R8 results from old operands");
   endtask

   task automatic t_busy_start;
      logic [31:0] d;
      load_ops(32'h0BAD_F00D);
      wr(4'd5, 32'h1);
      wr(4'd5, 32'h1);
      wait_done("R7 completion busy-start");
      repeat (150) @(negedge clk_f);
      rd(4'd5, d); check("R9 no second run", d, 32'h4);
      check_results("R9 results");
   endtask

   task automatic t_ignored_addrs;
      logic [31:0] d;
      wr(4'd7, 32'h5555_5555);
      rd(4'd7, d); check("R10 result write ignored", d, model(1));
      wr(4'd12, 32'h7777_7777);
      rd(4'd12, d); check("R10 unmapped reads 0", d, 0);
      wr(4'd5, 32'h0);
      rd(4'd5, d); check("R3 write 0 no start", d, 32'h4);
   endtask

   initial begin
      repeat (3) @(posedge clk_s);
      @(negedge clk_f); rst_f_n = 1;
      @(negedge clk_s); rst_s_n = 1;
      t_reset;
      t_basic(32'h0000_0001);
      t_basic(32'h8F3C_1E07);
      t_busy_writes;
      t_busy_start;
      t_ignored_addrs;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2_000_000;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule